// File: doc/BRIEF.md
# PPS-Aligned Clock and Trigger Sequencer

This block drives the timing lines toward an attached instrument. It divides a fast reference clock down to a 10 MHz output whose rising edge is pinned to the pulse-per-second (PPS) marker. It also raises an external trigger pulse at a commanded absolute time. That time is compared only at the 8 ns reference-tick resolution.

A small command-driven sequencer lets the instrument and this block zero their event and PPS counters together. A clear command forces both counters to zero and holds them there. An arm command, accepted only while the counters are held, makes the block wait for the next PPS. On that PPS it issues a trigger, releases the counters from zero and returns to normal counting. The current time (seconds and ticks), the tick strobe and the PPS strobe come from an external time-synchronisation core. Commands arrive as single-cycle strobes.

Top module: `pps_trig_seq`

## Requirements
- R1: After reset and until the first PPS strobe, `clk10_o` stays low.
- R2: In the cycle after a PPS strobe is sampled, `clk10_o` is high. From then on it repeats with a period of DIV_RATIO cycles: high while the cycle count since the PPS, modulo DIV_RATIO, is below (DIV_RATIO+1)/2, and low otherwise.
- R3: Every later PPS strobe restarts the divider phase, whatever its position in the current period. `clk10_o` is high in the following cycle and the R2 pattern restarts from there.
- R4: A schedule command is accepted when its target {seconds, ticks} is strictly greater than the current {`now_sec_i`, `now_tick_i`}, compared as one concatenated unsigned value. `ext_trig_o` then rises in the cycle after the clock edge at which `tick_en_i` is high and the current time equals the target.
- R5: Every trigger pulse stays high from its first cycle until the clock edge that sees the PULSE_TICKS-th tick strobe after its start, so it is PULSE_TICKS tick periods wide.
- R6: A schedule command whose target is not strictly later than the current time is dropped and raises no pulse. `sched_err_o` is set in the next cycle and stays set until reset.
- R7: A clear command moves `sync_state_o` to 1 (held) from any state. While it is held, `pps_count_o` and `event_count_o` read zero, and PPS and event strobes change neither counter.
- R8: An arm command in any state other than held (1) is ignored: the state is unchanged, and the next PPS raises no trigger.
- R9: In the held state an arm command moves the state to 2 (armed). The next PPS strobe then raises `ext_trig_o` in the following cycle, sets the state to 0 (running), and both counters read zero at that point.
- R10: In the running state (0), each PPS strobe adds one to `pps_count_o` and each event strobe adds one to `event_count_o`. Out of reset the state is running and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | One-cycle strobe per 8 ns time tick |
| pps_i | input | 1 | One-cycle PPS strobe |
| now_sec_i | input | SEC_W | Current time, seconds |
| now_tick_i | input | TICK_W | Current time, ticks within the second |
| sched_valid_i | input | 1 | Schedule-trigger command strobe |
| sched_sec_i | input | SEC_W | Target seconds |
| sched_tick_i | input | TICK_W | Target tick |
| cmd_clear_i | input | 1 | Clear-and-hold counters command |
| cmd_arm_i | input | 1 | Arm for restart on next PPS |
| event_i | input | 1 | Instrument event strobe |
| clk10_o | output | 1 | Divided, PPS-aligned clock |
| ext_trig_o | output | 1 | External trigger pulse |
| sched_err_o | output | 1 | Sticky late-schedule flag |
| sync_state_o | output | 2 | 0 running, 1 held, 2 armed |
| pps_count_o | output | CNT_W | PPS counter |
| event_count_o | output | CNT_W | Event counter |

## Verification
The bench builds the block with a divide ratio of 4, a two-tick trigger pulse, one tick every three cycles, a 3-bit tick field and a 4-bit seconds field. With these values every divider phase at which a realigning PPS can land is swept within a few dozen cycles. Scheduled targets cross seconds boundaries after a handful of ticks, and commands can be placed at each phase between tick strobes. Pulse widths then come out as exact products of tick count and tick period.

// File: rtl/ppsq_pkg.sv
package ppsq_pkg;
   typedef enum logic [1:0] {
      SQ_RUNNING = 2'd0,
      SQ_HELD    = 2'd1,
      SQ_ARMED   = 2'd2
   } sq_state_t;
endpackage

// File: rtl/ppsq_clk_div.sv
module ppsq_clk_div #(
   parameter int DIV_RATIO = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pps_i,
   output logic clk_o
);
   localparam int CW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
   localparam logic [CW-1:0] LAST   = CW'(DIV_RATIO - 1);
   localparam logic [CW-1:0] HIGH_C = CW'((DIV_RATIO + 1) / 2);

   if (DIV_RATIO < 2) begin : g_bad_div
      $error("DIV_RATIO must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nxt;
   logic          started_q;
   logic          out_q;

   always_comb cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         started_q <= 1'b0;
         out_q     <= 1'b0;
      end else if (pps_i) begin
         cnt_q     <= '0;
         started_q <= 1'b1;
         out_q     <= 1'b1;
      end else if (started_q) begin
         cnt_q <= cnt_nxt;
         out_q <= (cnt_nxt < HIGH_C);
      end
   end

   assign clk_o = out_q;

   assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !started_q |-> !clk_o);
   assert_period_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (started_q && !pps_i && cnt_q == LAST) |=> clk_o);
   assert_pps_realign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pps_i |=> (clk_o && cnt_q == '0));
endmodule

// File: rtl/ppsq_sched.sv
module ppsq_sched #(
   parameter int SEC_W  = 32,
   parameter int TICK_W = 27
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en_i,
   input  logic [SEC_W-1:0]  now_sec_i,
   input  logic [TICK_W-1:0] now_tick_i,
   input  logic              cmd_valid_i,
   input  logic [SEC_W-1:0]  cmd_sec_i,
   input  logic [TICK_W-1:0] cmd_tick_i,
   output logic              fire_o,
   output logic              err_o
);
   localparam int TW = SEC_W + TICK_W;

   if (SEC_W < 1 || TICK_W < 1) begin : g_bad_w
      $error("time field widths must be positive");
   end

   logic [TW-1:0] now_full;
   logic [TW-1:0] cmd_full;
   logic [TW-1:0] tgt_q;
   logic          pending_q;
   logic          err_q;

   assign now_full = {now_sec_i, now_tick_i};
   assign cmd_full = {cmd_sec_i, cmd_tick_i};
   assign fire_o   = pending_q && tick_en_i && (tgt_q == now_full);
   assign err_o    = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
         tgt_q     <= '0;
         err_q     <= 1'b0;
      end else begin
         if (fire_o) pending_q <= 1'b0;
         if (cmd_valid_i) begin
            if (cmd_full > now_full) begin
               pending_q <= 1'b1;
               tgt_q     <= cmd_full;
            end else begin
               err_q <= 1'b1;
            end
         end
      end
   end

   assert_fire_consumes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_o && !cmd_valid_i) |=> !pending_q);
   assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);
endmodule

// File: rtl/ppsq_pulse.sv
module ppsq_pulse #(
   parameter int WIDTH_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic tick_en_i,
   output logic pulse_o
);
   if (WIDTH_TICKS < 1) begin : g_bad_width
      $error("WIDTH_TICKS must be at least 1");
   end

   logic out_q;

   if (WIDTH_TICKS == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         out_q <= 1'b0;
         else if (start_i)   out_q <= 1'b1;
         else if (tick_en_i) out_q <= 1'b0;
      end
   end else begin : g_multi
      localparam int RW = $clog2(WIDTH_TICKS + 1);
      logic [RW-1:0] rem_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_q <= 1'b0;
            rem_q <= '0;
         end else if (start_i) begin
            out_q <= 1'b1;
            rem_q <= RW'(WIDTH_TICKS);
         end else if (out_q && tick_en_i) begin
            if (rem_q == RW'(1)) begin
               out_q <= 1'b0;
               rem_q <= '0;
            end else begin
               rem_q <= rem_q - 1'b1;
            end
         end
      end
   end

   assign pulse_o = out_q;

   assert_start_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> pulse_o);
   assert_no_tick_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_o && !tick_en_i) |=> pulse_o);
endmodule

// File: rtl/ppsq_sync_fsm.sv
module ppsq_sync_fsm
   import ppsq_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_clear_i,
   input  logic             cmd_arm_i,
   input  logic             pps_i,
   input  logic             event_i,
   output sq_state_t        state_o,
   output logic [CNT_W-1:0] pps_cnt_o,
   output logic [CNT_W-1:0] evt_cnt_o,
   output logic             sync_fire_o
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be positive");
   end

   sq_state_t        state_q;
   logic [CNT_W-1:0] pps_q;
   logic [CNT_W-1:0] evt_q;

   assign sync_fire_o = (state_q == SQ_ARMED) && pps_i && !cmd_clear_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_RUNNING;
      end else if (cmd_clear_i) begin
         state_q <= SQ_HELD;
      end else begin
         case (state_q)
            SQ_HELD:  if (cmd_arm_i) state_q <= SQ_ARMED;
            SQ_ARMED: if (pps_i)     state_q <= SQ_RUNNING;
            default:  state_q <= state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pps_q <= '0;
         evt_q <= '0;
      end else if (cmd_clear_i || state_q != SQ_RUNNING) begin
         pps_q <= '0;
         evt_q <= '0;
      end else begin
         if (pps_i)   pps_q <= pps_q + 1'b1;
         if (event_i) evt_q <= evt_q + 1'b1;
      end
   end

   assign state_o   = state_q;
   assign pps_cnt_o = pps_q;
   assign evt_cnt_o = evt_q;

   assert_held_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == SQ_HELD) |-> (pps_cnt_o == '0 && evt_cnt_o == '0));
   assert_arm_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == SQ_RUNNING && !cmd_clear_i) |=> state_o == SQ_RUNNING);
   assert_restart_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sync_fire_o |=> (state_o == SQ_RUNNING && pps_cnt_o == '0 && evt_cnt_o == '0));
   assert_pps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == SQ_RUNNING && !cmd_clear_i && pps_i)
      |=> pps_cnt_o == CNT_W'($past(pps_cnt_o) + 1'b1));
endmodule

// File: rtl/pps_trig_seq.sv
module pps_trig_seq
   import ppsq_pkg::*;
#(
   parameter int DIV_RATIO   = 20,
   parameter int PULSE_TICKS = 4,
   parameter int SEC_W       = 32,
   parameter int TICK_W      = 27,
   parameter int CNT_W       = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en_i,
   input  logic              pps_i,
   input  logic [SEC_W-1:0]  now_sec_i,
   input  logic [TICK_W-1:0] now_tick_i,
   input  logic              sched_valid_i,
   input  logic [SEC_W-1:0]  sched_sec_i,
   input  logic [TICK_W-1:0] sched_tick_i,
   input  logic              cmd_clear_i,
   input  logic              cmd_arm_i,
   input  logic              event_i,
   output logic              clk10_o,
   output logic              ext_trig_o,
   output logic              sched_err_o,
   output logic [1:0]        sync_state_o,
   output logic [CNT_W-1:0]  pps_count_o,
   output logic [CNT_W-1:0]  event_count_o
);
   logic      sched_fire;
   logic      sync_fire;
   sq_state_t state;

   ppsq_clk_div #(.DIV_RATIO(DIV_RATIO)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .pps_i (pps_i),
      .clk_o (clk10_o)
   );

   ppsq_sched #(.SEC_W(SEC_W), .TICK_W(TICK_W)) u_sched (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_en_i   (tick_en_i),
      .now_sec_i   (now_sec_i),
      .now_tick_i  (now_tick_i),
      .cmd_valid_i (sched_valid_i),
      .cmd_sec_i   (sched_sec_i),
      .cmd_tick_i  (sched_tick_i),
      .fire_o      (sched_fire),
      .err_o       (sched_err_o)
   );

   ppsq_sync_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_clear_i (cmd_clear_i),
      .cmd_arm_i   (cmd_arm_i),
      .pps_i       (pps_i),
      .event_i     (event_i),
      .state_o     (state),
      .pps_cnt_o   (pps_count_o),
      .evt_cnt_o   (event_count_o),
      .sync_fire_o (sync_fire)
   );

   ppsq_pulse #(.WIDTH_TICKS(PULSE_TICKS)) u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (sched_fire || sync_fire),
      .tick_en_i (tick_en_i),
      .pulse_o   (ext_trig_o)
   );

   assign sync_state_o = state;
endmodule

// File: tb/pps_trig_seq_tb.sv
module pps_trig_seq_tb;
   localparam int DIV = 4;
   localparam int HI  = (DIV + 1) / 2;
   localparam int W   = 2;
   localparam int TP  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b1;
   logic pps = 1'b0;
   logic [6:0] now_full = '0;
   logic sched_valid = 1'b0;
   logic [6:0] tgt = '0;
   logic cmd_clear = 1'b0, cmd_arm = 1'b0, event_s = 1'b0;
   logic clk10, trig, err;
   logic [1:0] state;
   logic [7:0] pps_cnt, evt_cnt;
   int ph = 0;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pps_trig_seq #(.DIV_RATIO(DIV), .PULSE_TICKS(W), .SEC_W(4), .TICK_W(3), .CNT_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en), .pps_i(pps),
      .now_sec_i(now_full[6:3]), .now_tick_i(now_full[2:0]),
      .sched_valid_i(sched_valid), .sched_sec_i(tgt[6:3]), .sched_tick_i(tgt[2:0]),
      .cmd_clear_i(cmd_clear), .cmd_arm_i(cmd_arm), .event_i(event_s),
      .clk10_o(clk10), .ext_trig_o(trig), .sched_err_o(err),
      .sync_state_o(state), .pps_count_o(pps_cnt), .event_count_o(evt_cnt));

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      if (tick_en) now_full = now_full + 7'd1;
      ph = (ph + 1) % TP;
      tick_en = (ph == 0);
   endtask

   task automatic wait_tick();
      while (!tick_en) cyc();
   endtask

   task automatic pulse_pps();
      pps = 1'b1; cyc(); pps = 1'b0;
   endtask

   task automatic pulse_event();
      event_s = 1'b1; cyc(); event_s = 1'b0; cyc();
   endtask

   task automatic run_sched(int d, int off, string req);
      int first = -1;
      int high = 0;
      int expk;
      wait_tick();
      for (int i = 0; i < off; i++) cyc();
      tgt = now_full + 7'(d);
      sched_valid = 1'b1; cyc(); sched_valid = 1'b0;
      expk = (off == 0) ? d * TP : (TP - off) + d * TP;
      for (int k = 1; k <= expk + W * TP + 4; k++) begin
         cyc();
         if (trig && first < 0) first = k;
         if (trig) high++;
      end
      chk({req, " R4 first trigger cycle"}, first, expk);
      chk({req, " R5 trigger width"}, high, W * TP);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) cyc();
      rst_n = 1'b1;
      cyc();
      chk("R1 reset clk10", clk10, 0);
      chk("R5 reset trigger", trig, 0);
      chk("R6 reset err", err, 0);
      chk("R10 reset state", state, 0);
      chk("R10 reset pps count", pps_cnt, 0);
      chk("R10 reset event count", evt_cnt, 0);
      begin
         int seen = 0;
         for (int i = 0; i < 10; i++) begin cyc(); seen += clk10; end
         chk("R1 clk10 low before PPS", seen, 0);
      end

      // R2: first PPS starts the divider
      pulse_pps();
      chk("R2 high after first PPS", clk10, 1);
      begin
         int bad = 0;
         for (int n = 1; n <= 3 * DIV; n++) begin
            cyc();
            if (clk10 != ((n % DIV) < HI)) bad++;
         end
         chk("R2 divider pattern", bad, 0);
      end

      // R3: realign at every phase
      for (int off = 1; off <= DIV + 1; off++) begin
         int bad = 0;
         for (int i = 0; i < off; i++) cyc();
         pulse_pps();
         if (clk10 != 1'b1) bad++;
         for (int n = 1; n <= 2 * DIV; n++) begin
            cyc();
            if (clk10 != ((n % DIV) < HI)) bad++;
         end
         chk("R3 realign pattern", bad, 0);
      end

      // R4/R5: scheduled triggers, tick-aligned and between ticks, across seconds
      for (int d = 1; d <= 10; d++) run_sched(d, 0, "aligned");
      for (int off = 1; off < TP; off++)
         for (int d = 1; d <= 2; d++) run_sched(d, off, "unaligned");
      chk("R6 err stays clear after valid commands", err, 0);

      // R6: late targets rejected
      begin
         int seen = 0;
         wait_tick();
         tgt = now_full - 7'd3;
         sched_valid = 1'b1; cyc(); sched_valid = 1'b0;
         chk("R6 err after past target", err, 1);
         wait_tick();
         tgt = now_full;
         sched_valid = 1'b1; cyc(); sched_valid = 1'b0;
         for (int i = 0; i < 6 * TP; i++) begin cyc(); seen += trig; end
         chk("R6 no pulse for late targets", seen, 0);
         chk("R6 err sticky", err, 1);
      end

      // R7: clear and hold
      cmd_clear = 1'b1; cyc(); cmd_clear = 1'b0;
      chk("R7 state held", state, 1);
      for (int i = 0; i < 3; i++) pulse_event();
      pulse_pps(); cyc();
      chk("R7 pps count held", pps_cnt, 0);
      chk("R7 event count held", evt_cnt, 0);
      chk("R7 no trigger while held", trig, 0);

      // R9: arm then restart on next PPS
      cmd_arm = 1'b1; cyc(); cmd_arm = 1'b0;
      chk("R9 state armed", state, 2);
      pulse_event(); pulse_event();
      chk("R9 events ignored while armed", evt_cnt, 0);
      wait_tick();
      pulse_pps();
      chk("R9 trigger after PPS", trig, 1);
      chk("R9 state running", state, 0);
      chk("R9 pps count zero", pps_cnt, 0);
      chk("R9 event count zero", evt_cnt, 0);
      begin
         int high = 1;
         for (int i = 0; i < W * TP + 4; i++) begin cyc(); high += trig; end
         chk("R5 sync trigger width", high, W * TP);
      end

      // R10: counting while running
      for (int i = 0; i < 5; i++) pulse_event();
      pulse_pps(); cyc();
      chk("R10 event count", evt_cnt, 5);
      chk("R10 pps count", pps_cnt, 1);

      // R8: arm outside held is ignored
      cmd_arm = 1'b1; cyc(); cmd_arm = 1'b0;
      chk("R8 state unchanged", state, 0);
      wait_tick();
      pulse_pps();
      chk("R8 no trigger on PPS", trig, 0);
      chk("R8 pps counted", pps_cnt, 2);
      chk("R8 state still running", state, 0);

      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule